// File: doc/BRIEF.md
# Multi-Channel Register-Programmed PWM Bank

This block holds up to eight independent pulse-width channels behind a small memory-mapped register bus. Each channel owns a window of three registers: a control word with a power-of-two clock-divider exponent and a waveform-mode bit, a 13-bit period count and a 13-bit duty threshold. One shared enable word starts and stops the channels, one bit each. A global clock-select register decides what advances the counters: every bus clock, or a single-cycle tick from a fixed reference source supplied on `ref_tick` and already synchronous to `clk`.

A running channel divides its tick stream by 2^exponent, counts from 0 to period-1 and wraps. Its output is high while the count is below the threshold. New settings written while the channel runs are held in the register file and only copied into the counting logic at the next wrap, so a waveform never carries a partial pulse. The bus is a plain single-cycle write strobe with combinational read data. Since the outputs are level signals and the bus has no transfer handshake, no valid/ready flow control applies.

Top module: `pwm_bank`

## Requirements
- R1: After reset every implemented register reads 0, the clock select reads 0 (bus clock) and all `pwm_out` bits are low.
- R2: The enable word at byte address 0x000 holds one bit per channel (bit n runs channel n). It reads back exactly the bits written for the implemented channels, and the upper bits read 0.
- R3: Channel n's window starts at 0x010 + 0x40·n for n = 0..6 and at 0x220 for channel 7. Within a window, +0x00 is control (bits 2:0 are the divider exponent, bit 15 is the waveform-mode bit), +0x2C is the period and +0x30 is the threshold. Period and threshold keep 13 bits, and control reads back only bits 15 and 2:0.
- R4: A running channel's count advances once every 2^exponent ticks. It goes 0..period-1 and then wraps to 0, where a period of 0 behaves as 1. Its output is high exactly while count < threshold.
- R5: A threshold of 0 gives a constant low output. A threshold greater than or equal to the period gives a constant high output.
- R6: Period, threshold, divider and mode values written while the channel runs take effect only from the count-0 cycle after the next wrap.
- R7: Clearing a channel's enable bit drives its output low in the cycle after the write and holds its count at zero. Setting the bit starts a fresh period at count 0, using the current register values.
- R8: The clock select at 0x210 stores whether the written value was nonzero and reads back 1 or 0. With 0, every bus clock is a tick. With 1, only cycles with `ref_tick` high are ticks.
- R9: A channel whose active mode bit (control bit 15) is 0 keeps its output low while enabled.
- R10: Addresses that map to no register read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ref_tick | input | 1 | Reference-clock tick, one cycle wide, synchronous to `clk` |
| pwm_out | output | 8 | Per-channel waveform outputs |

## Verification
The hardest case to reach is the deferred update. A new period and threshold must land in the middle of a running period, and then the rest of that period has to be shown to follow the old values exactly. The bench enables a channel, lets a known number of cycles pass, writes the new values partway through the count, and compares every cycle against a model that switches only at the wrap index. Reference-clock counting is reached by holding `ref_tick` low to show that the counter is frozen, then pulsing it one cycle at a time.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int DIV_W    = 3;
  localparam int PER_W    = 13;
  localparam int PRE_W    = (1 << DIV_W) - 1;
  localparam int MODE_BIT = 15;

  localparam logic [ADDR_W-1:0] EN_ADDR   = 12'h000;
  localparam logic [ADDR_W-1:0] CSEL_ADDR = 12'h210;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_PER   = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_THR   = 12'h030;

  typedef struct packed {
    logic             mode;
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] thr;
  } ch_cfg_t;

  // Window base: regular 0x40 stride, last channel relocated.
  function automatic logic [ADDR_W-1:0] ch_base(input int n);
    if (n == 7) return 12'h220;
    return ADDR_W'(12'h010 + 12'h040 * n);
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [NUM_CH-1:0]             en,
  output logic                          ref_sel,
  output ch_cfg_t [NUM_CH-1:0]          cfg
);
  logic hit;

  always_comb begin
    hit   = (addr == EN_ADDR) || (addr == CSEL_ADDR);
    rdata = '0;
    if (addr == EN_ADDR)   rdata[NUM_CH-1:0] = en;
    if (addr == CSEL_ADDR) rdata[0]          = ref_sel;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ch_base(c) + OFF_CTRL) begin
        hit                 = 1'b1;
        rdata[MODE_BIT]     = cfg[c].mode;
        rdata[DIV_W-1:0]    = cfg[c].div;
      end
      if (addr == ch_base(c) + OFF_PER) begin
        hit              = 1'b1;
        rdata[PER_W-1:0] = cfg[c].per;
      end
      if (addr == ch_base(c) + OFF_THR) begin
        hit              = 1'b1;
        rdata[PER_W-1:0] = cfg[c].thr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= '0;
      ref_sel <= 1'b0;
      cfg     <= '0;
    end else if (wr_en) begin
      if (addr == EN_ADDR)   en      <= wdata[NUM_CH-1:0];
      if (addr == CSEL_ADDR) ref_sel <= |wdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ch_base(c) + OFF_CTRL) begin
          cfg[c].mode <= wdata[MODE_BIT];
          cfg[c].div  <= wdata[DIV_W-1:0];
        end
        if (addr == ch_base(c) + OFF_PER) cfg[c].per <= wdata[PER_W-1:0];
        if (addr == ch_base(c) + OFF_THR) cfg[c].thr <= wdata[PER_W-1:0];
      end
    end
  end

  // R2: enable word holds exactly what was written
  assert_enable_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EN_ADDR) |=> (en == $past(wdata[NUM_CH-1:0])));

  // R10: writes to unmapped addresses leave every register untouched
  assert_unmapped_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(en) && $stable(ref_sel) && $stable(cfg)));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  ch_cfg_t cfg,
  output logic    pwm
);
  ch_cfg_t          act;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pre_mask;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last;
  logic             step;
  logic             wrap;

  always_comb begin
    pre_mask = ~({PRE_W{1'b1}} << act.div);
    last     = (act.per == '0) ? '0 : act.per - PER_W'(1);
    step     = tick && (pre == pre_mask);
    wrap     = step && (cnt >= last);
    pwm      = run && act.mode && (cnt < act.thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= '0;
      pre <= '0;
      cnt <= '0;
    end else if (!run) begin
      act <= cfg;
      pre <= '0;
      cnt <= '0;
    end else if (tick) begin
      if (step) begin
        pre <= '0;
        if (wrap) begin
          cnt <= '0;
          act <= cfg;
        end else begin
          cnt <= cnt + PER_W'(1);
        end
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  // R4: count never passes the last index of the active period
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R4: prescaler stays inside its 2^exponent window
  assert_prescale_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= pre_mask);

  // R6: active settings change only at a wrap while running
  assert_deferred_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act));

  // R7: a stopped channel holds its count and prescaler at zero
  assert_stopped_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && pre == '0));

  // R5: a high output needs a nonzero active threshold
  assert_zero_thr_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pwm |-> (act.thr != '0));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              ref_tick,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]    en;
  logic                 ref_sel;
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic                 tick;

  assign tick = ref_sel ? ref_tick : 1'b1;

  pwm_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .en      (en),
    .ref_sel (ref_sel),
    .cfg     (cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en[g]),
      .tick  (tick),
      .cfg   (cfg[g]),
      .pwm   (pwm_out[g])
    );
  end

  // R7: output of a disabled channel is low
  assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~en) & pwm_out) == '0);
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int NUM_CH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b0;
  logic [NUM_CH-1:0] pwm_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ref_tick(ref_tick), .pwm_out(pwm_out)
  );

  // div, period, threshold
  localparam logic [39:0] VEC [0:8] = '{
    {8'd0, 16'd5, 16'd2}, {8'd1, 16'd4, 16'd1}, {8'd2, 16'd3, 16'd2},
    {8'd0, 16'd6, 16'd0}, {8'd0, 16'd4, 16'd4}, {8'd0, 16'd3, 16'd9},
    {8'd3, 16'd2, 16'd1}, {8'd0, 16'd7, 16'd3}, {8'd0, 16'd0, 16'd1}
  };

  function automatic logic [11:0] base(input int n);
    return (n == 7) ? 12'h220 : 12'(12'h010 + 12'h040 * n);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic setup_ch(input int ch, input int dv, input int per, input int thr);
    wr(base(ch) + 12'h000, 32'h8000 | 32'(dv));
    wr(base(ch) + 12'h02C, 32'(per));
    wr(base(ch) + 12'h030, 32'(thr));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(12'h000, 32'h0, "R1 enable");
    rd_chk(12'h210, 32'h0, "R1 clock select");
    rd_chk(12'h010, 32'h0, "R1 ctrl");
    rd_chk(12'h03C, 32'h0, "R1 period");
    rd_chk(12'h040, 32'h0, "R1 threshold");
    chk(pwm_out == '0, "R1 outputs", 32'(pwm_out), 32'h0);

    // R2 enable readback
    wr(12'h000, 32'hFFFF_FFA5);
    rd_chk(12'h000, 32'h0000_00A5, "R2 enable readback");
    wr(12'h000, 32'h0);

    // R3 field widths and channel 7 relocation
    wr(base(2) + 12'h000, 32'hFFFF_FFFF);
    rd_chk(base(2) + 12'h000, 32'h0000_8007, "R3 ctrl bits");
    wr(base(2) + 12'h02C, 32'hFFFF_FFFF);
    rd_chk(base(2) + 12'h02C, 32'h0000_1FFF, "R3 period width");
    wr(base(7) + 12'h02C, 32'h0000_0123);
    rd_chk(12'h24C, 32'h0000_0123, "R3 ch7 window");
    rd_chk(12'h1FC, 32'h0, "R3 no linear ch7 window");
    wr(base(2) + 12'h000, 32'h0);
    wr(base(2) + 12'h02C, 32'h0);

    // R10 unmapped addresses
    wr(base(0) + 12'h030, 32'h0000_0011);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h1D0, 32'hFFFF_FFFF);
    rd_chk(12'h014, 32'h0, "R10 unmapped read");
    rd_chk(12'h1D0, 32'h0, "R10 unmapped read hole");
    rd_chk(base(0) + 12'h030, 32'h11, "R10 neighbour untouched");
    rd_chk(12'h000, 32'h0, "R10 enable untouched");
    chk(pwm_out == '0, "R10 outputs untouched", 32'(pwm_out), 32'h0);

    // R4 R5 R3 vector table
    for (int k = 0; k < 9; k++) begin
      int ch, dv, per, thr, p, n, bad;
      logic [NUM_CH-1:0] first_act, first_exp;
      string tag;
      ch  = k % NUM_CH;
      dv  = int'(VEC[k][39:32]);
      per = int'(VEC[k][31:16]);
      thr = int'(VEC[k][15:0]);
      p   = (per == 0) ? 1 : per;
      n   = 2 * (p << dv) + 2;
      bad = 0;
      first_act = '0; first_exp = '0;
      wr(12'h000, 32'h0);
      setup_ch(ch, dv, per, thr);
      wr(12'h000, 32'(1) << ch);
      for (int i = 0; i < n; i++) begin
        logic [NUM_CH-1:0] e;
        e = '0;
        e[ch] = (((i >> dv) % p) < thr);
        if (pwm_out !== e && bad == 0) begin
          first_act = pwm_out; first_exp = e;
        end
        if (pwm_out !== e) bad++;
        @(negedge clk);
      end
      tag = (thr == 0 || thr >= p) ? "R5 vector" : (ch == 7 ? "R3 R4 vector" : "R4 vector");
      chk(bad == 0, tag, 32'(first_act), 32'(first_exp));
    end
    wr(12'h000, 32'h0);

    // R6 deferred update
    begin
      int bad;
      logic [NUM_CH-1:0] fa, fe;
      bad = 0; fa = '0; fe = '0;
      setup_ch(0, 0, 8, 4);
      wr(12'h000, 32'h1);
      for (int i = 0; i < 22; i++) begin
        logic [NUM_CH-1:0] e;
        e = '0;
        e[0] = (i < 8) ? (i < 4) : (((i - 8) % 5) < 2);
        if (pwm_out !== e && bad == 0) begin fa = pwm_out; fe = e; end
        if (pwm_out !== e) bad++;
        if (i == 2) wr(base(0) + 12'h02C, 32'd5);
        else if (i == 4) wr(base(0) + 12'h030, 32'd2);
        else @(negedge clk);
        if (i == 2 || i == 4) begin
          i++;
          e = '0;
          e[0] = (i < 4);
          if (pwm_out !== e && bad == 0) begin fa = pwm_out; fe = e; end
          if (pwm_out !== e) bad++;
          @(negedge clk);
        end
      end
      chk(bad == 0, "R6 deferred update", 32'(fa), 32'(fe));
    end

    // R7 disable and fresh restart
    wr(12'h000, 32'h0);
    setup_ch(0, 0, 8, 4);
    wr(12'h000, 32'h1);
    repeat (5) @(negedge clk);
    chk(pwm_out[0] == 1'b0, "R7 mid period low", 32'(pwm_out), 32'h0);
    wr(12'h000, 32'h0);
    chk(pwm_out == '0, "R7 disabled low", 32'(pwm_out), 32'h0);
    wr(12'h000, 32'h1);
    chk(pwm_out == 8'h01, "R7 restart at count 0", 32'(pwm_out), 32'h1);
    repeat (3) @(negedge clk);
    chk(pwm_out == 8'h01, "R7 restart count 3", 32'(pwm_out), 32'h1);
    @(negedge clk);
    chk(pwm_out == 8'h00, "R7 restart count 4", 32'(pwm_out), 32'h0);
    wr(12'h000, 32'h0);

    // R9 mode bit clear
    wr(base(3) + 12'h000, 32'h0);
    wr(base(3) + 12'h02C, 32'd4);
    wr(base(3) + 12'h030, 32'd4);
    wr(12'h000, 32'h8);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 10; i++) begin
        if (pwm_out != '0) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R9 mode clear low", 32'(hi), 32'h0);
    end
    wr(12'h000, 32'h0);

    // R8 reference clock
    wr(12'h210, 32'h0000_0040);
    rd_chk(12'h210, 32'h1, "R8 select readback");
    setup_ch(1, 0, 2, 1);
    wr(12'h000, 32'h2);
    repeat (5) @(negedge clk);
    chk(pwm_out == 8'h02, "R8 frozen without tick", 32'(pwm_out), 32'h2);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(pwm_out == 8'h00, "R8 one tick advances", 32'(pwm_out), 32'h0);
    repeat (3) @(negedge clk);
    chk(pwm_out == 8'h00, "R8 holds between ticks", 32'(pwm_out), 32'h0);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    chk(pwm_out == 8'h02, "R8 second tick wraps", 32'(pwm_out), 32'h2);
    wr(12'h210, 32'h0);
    rd_chk(12'h210, 32'h0, "R8 bus clock readback");
    @(negedge clk);
    chk(pwm_out == 8'h00, "R8 bus clock counts", 32'(pwm_out), 32'h0);
    wr(12'h000, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule